// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block sits beside a processor's instruction pipeline and owns the privilege state that traps and trap returns change. It holds the current privilege level and the per-level interrupt-enable bits: the live enable bit, the saved copy of that bit, and the saved previous level. It also holds the cause, exception PC and trap-value registers for the machine, supervisor and user levels. When the pipeline reports a synchronous exception, the block chooses the level that handles it from two delegation masks. When an interrupt is taken, the block uses the level supplied with it. It then saves the faulting PC and cause information, updates the status bits and produces the handler address.

When the pipeline retires a machine, supervisor or user return, the block restores the enable bit and the privilege from the saved fields. It then produces the return address taken from the matching exception-PC register. Every trap and every return raises a one-cycle pulse that tells the memory system to drop any load-reserved reservation. The delegation masks and the trap-vector bases come from the CSR file as level inputs. Privilege codes are user = 0, supervisor = 1, machine = 3.

Top module: `trap_return_seq`

## Requirements
- R1: After reset the privilege is machine (3), every status bit and the saved-level fields are 0, all cause, exception-PC and trap-value registers are 0, and `nextPcValid`, `resvCancel` and `tvecErr` are low.
- R2: For an exception, bit `causeCode` of `medeleg` selects delegation away from machine level. If that bit and bit `causeCode` of `sedeleg` are both set, the target is user level. If only the `medeleg` bit is set, the target is supervisor. Otherwise the target is machine level.
- R3: When the target level of an exception, or the `intLevel` of an interrupt, is numerically below the current privilege, the trap is taken at the current privilege.
- R4: A machine-level trap performs these updates:
  - the saved machine enable takes the live machine enable, and the live machine enable clears;
  - the saved machine level takes the old privilege;
  - `mepc` takes `faultPc`;
  - `mtval` takes `infoVal` if `infoValid` is high, else 0;
  - `mcause` takes `causeCode` zero-extended, with bit XLEN-1 set for interrupts.
- R5: A supervisor-level trap updates the supervisor enable pair the same way. It sets the saved supervisor level to 1 when the trap comes from supervisor and to 0 when it comes from user. It writes `sepc`, `stval` and `scause` as in R4.
- R6: A user-level trap copies the live user enable into the saved user enable, clears the live user enable, and writes `uepc`, `utval` and `ucause` as in R4.
- R7: The handler address is the selected vector with bits [1:0] cleared. The vector's bits [1:0] set the mode:
  - 00: the handler address is the base;
  - 01: for interrupts the address is base + 4×cause, and for exceptions it is the base;
  - 1x: the address is the base and `tvecErr` pulses.
- R8: A machine return copies the saved machine enable into the live one, sets the saved enable to 1, moves to the privilege held in the saved machine level, and then resets that field to user (or to machine when user mode is absent).
- R9: A supervisor return copies the saved supervisor enable into the live one, sets the saved enable to 1, moves to supervisor if the saved supervisor level is 1 and to user otherwise, and then clears that field.
- R10: A user return copies the saved user enable into the live one, sets the saved enable to 1, and leaves the privilege at user.
- R11: The return address is the matching exception-PC register with bit 0 cleared.
- R12: The cycle after any trap or return request, `nextPcValid` and `resvCancel` are both high for exactly one cycle. With no request, neither pulses and the privilege holds.
- R13: When requests coincide, an exception wins over an interrupt, an interrupt over a machine return, then supervisor return, then user return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| excValid | input | 1 | Synchronous exception request |
| intValid | input | 1 | Interrupt trap request |
| mretReq | input | 1 | Machine return request |
| sretReq | input | 1 | Supervisor return request |
| uretReq | input | 1 | User return request |
| causeCode | input | CODE_W | Exception or interrupt code |
| intLevel | input | 2 | Level chosen for an interrupt |
| faultPc | input | XLEN | PC of the trapping instruction |
| infoValid | input | 1 | Trap value supplied |
| infoVal | input | XLEN | Trap value |
| medeleg | input | XLEN | Machine exception-delegation mask |
| sedeleg | input | XLEN | Supervisor exception-delegation mask |
| mtvec | input | XLEN | Machine vector base and mode |
| stvec | input | XLEN | Supervisor vector base and mode |
| utvec | input | XLEN | User vector base and mode |
| curPriv | output | 2 | Current privilege |
| statMie | output | 1 | Machine interrupt enable |
| statMpie | output | 1 | Saved machine enable |
| statMpp | output | 2 | Saved machine previous level |
| statSie | output | 1 | Supervisor interrupt enable |
| statSpie | output | 1 | Saved supervisor enable |
| statSpp | output | 1 | Saved supervisor previous level |
| statUie | output | 1 | User interrupt enable |
| statUpie | output | 1 | Saved user enable |
| mcause | output | XLEN | Machine cause |
| mepc | output | XLEN | Machine exception PC |
| mtval | output | XLEN | Machine trap value |
| scause | output | XLEN | Supervisor cause |
| sepc | output | XLEN | Supervisor exception PC |
| stval | output | XLEN | Supervisor trap value |
| ucause | output | XLEN | User cause |
| uepc | output | XLEN | User exception PC |
| utval | output | XLEN | User trap value |
| nextPc | output | XLEN | Handler or return address |
| nextPcValid | output | 1 | One-cycle strobe for nextPc |
| resvCancel | output | 1 | One-cycle reservation cancel |
| tvecErr | output | 1 | Illegal vector mode on this trap |

## Verification
The assertions check the following on every cycle:
- any request produces the cancel and next-PC strobes one cycle later;
- an idle cycle leaves the privilege and strobes quiet;
- an exception never lowers the privilege;
- a machine-level trap leaves machine interrupts disabled;
- each return kind puts its saved enable and saved level in the restored state.

The rest can only be shown by the bench's directed scenarios:
- the delegation choice for specific mask bits;
- the saved-level value written on a supervisor trap;
- the cause, PC and trap-value contents;
- vectored and illegal-mode handler addresses;
- the aligned return address.

// File: rtl/trap_return_seq_pkg.sv
package trap_return_seq_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  typedef struct packed {
    logic trapM;
    logic trapS;
    logic trapU;
    logic isIntr;
    logic doMret;
    logic doSret;
    logic doUret;
  } seqStrobe_t;
endpackage

// File: rtl/trap_return_seq_ctrl.sv
module trap_return_seq_ctrl
  import trap_return_seq_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CODE_W    = 5,
  parameter bit HAVE_SUP  = 1'b1,
  parameter bit HAVE_USR  = 1'b1,
  parameter bit HAVE_UEXT = 1'b1
) (
  input  logic              excValid,
  input  logic              intValid,
  input  logic              mretReq,
  input  logic              sretReq,
  input  logic              uretReq,
  input  logic [CODE_W-1:0] causeCode,
  input  logic [1:0]        intLevel,
  input  logic [1:0]        curPriv,
  input  logic [XLEN-1:0]   medeleg,
  input  logic [XLEN-1:0]   sedeleg,
  output seqStrobe_t        strobe
);
  logic       superDel, userDel, anyTrap;
  logic [1:0] excLevel, reqLevel, tgtLevel;

  always_comb begin
    // layered delegation: machine mask first, then onward to user
    superDel = medeleg[causeCode];
    userDel  = superDel & HAVE_UEXT & (HAVE_SUP ? sedeleg[causeCode] : 1'b1);
    if (HAVE_USR && userDel)       excLevel = PRIV_U;
    else if (HAVE_SUP && superDel) excLevel = PRIV_S;
    else                           excLevel = PRIV_M;

    reqLevel = excValid ? excLevel : intLevel;
    // never handle at a level below the current one
    tgtLevel = (reqLevel < curPriv) ? curPriv : reqLevel;

    anyTrap       = excValid | intValid;
    strobe        = '0;
    strobe.trapM  = anyTrap && tgtLevel[1];
    strobe.trapS  = anyTrap && (tgtLevel == PRIV_S);
    strobe.trapU  = anyTrap && (tgtLevel == PRIV_U);
    strobe.isIntr = !excValid && intValid;
    strobe.doMret = !anyTrap && mretReq;
    strobe.doSret = !anyTrap && !mretReq && sretReq;
    strobe.doUret = !anyTrap && !mretReq && !sretReq && uretReq;
  end
endmodule

// File: rtl/trap_return_seq_dpath.sv
module trap_return_seq_dpath
  import trap_return_seq_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int CODE_W   = 5,
  parameter bit HAVE_USR = 1'b1,
  parameter bit HAVE_RVC = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [CODE_W-1:0] causeCode,
  input  logic [XLEN-1:0]   faultPc,
  input  logic              infoValid,
  input  logic [XLEN-1:0]   infoVal,
  input  logic [XLEN-1:0]   mtvec,
  input  logic [XLEN-1:0]   stvec,
  input  logic [XLEN-1:0]   utvec,
  output logic [1:0]        curPriv,
  output logic              statMie,
  output logic              statMpie,
  output logic [1:0]        statMpp,
  output logic              statSie,
  output logic              statSpie,
  output logic              statSpp,
  output logic              statUie,
  output logic              statUpie,
  output logic [XLEN-1:0]   mcause,
  output logic [XLEN-1:0]   mepc,
  output logic [XLEN-1:0]   mtval,
  output logic [XLEN-1:0]   scause,
  output logic [XLEN-1:0]   sepc,
  output logic [XLEN-1:0]   stval,
  output logic [XLEN-1:0]   ucause,
  output logic [XLEN-1:0]   uepc,
  output logic [XLEN-1:0]   utval,
  output logic [XLEN-1:0]   nextPc,
  output logic              nextPcValid,
  output logic              resvCancel,
  output logic              tvecErr
);
  localparam logic [XLEN-1:0] ALIGN_MASK = HAVE_RVC ? ~XLEN'(1) : ~XLEN'(3);
  localparam logic [1:0]      RET_MPP    = HAVE_USR ? PRIV_U : PRIV_M;

  logic            anyTrap, anyRet, modeErr;
  logic [XLEN-1:0] selTvec, vecBase, trapPc, retPc, causeWord, tvalWord;

  always_comb begin
    anyTrap = strobe.trapM | strobe.trapS | strobe.trapU;
    anyRet  = strobe.doMret | strobe.doSret | strobe.doUret;
    selTvec = strobe.trapM ? mtvec : (strobe.trapS ? stvec : utvec);
    vecBase = {selTvec[XLEN-1:2], 2'b00};
    modeErr = 1'b0;
    case (selTvec[1:0])
      2'b00:   trapPc = vecBase;
      2'b01:   trapPc = strobe.isIntr ? vecBase + (XLEN'(causeCode) << 2) : vecBase;
      default: begin trapPc = vecBase; modeErr = 1'b1; end
    endcase
    retPc = (strobe.doMret ? mepc : (strobe.doSret ? sepc : uepc)) & ALIGN_MASK;
    causeWord = XLEN'(causeCode);
    causeWord[XLEN-1] = strobe.isIntr;
    tvalWord = infoValid ? infoVal : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPriv  <= PRIV_M;
      statMie  <= 1'b0; statMpie <= 1'b0; statMpp <= PRIV_U;
      statSie  <= 1'b0; statSpie <= 1'b0; statSpp <= 1'b0;
      statUie  <= 1'b0; statUpie <= 1'b0;
      mcause <= '0; mepc <= '0; mtval <= '0;
      scause <= '0; sepc <= '0; stval <= '0;
      ucause <= '0; uepc <= '0; utval <= '0;
      nextPc <= '0; nextPcValid <= 1'b0; resvCancel <= 1'b0; tvecErr <= 1'b0;
    end else begin
      nextPcValid <= anyTrap | anyRet;
      resvCancel  <= anyTrap | anyRet;
      tvecErr     <= anyTrap & modeErr;
      if (anyTrap)     nextPc <= trapPc;
      else if (anyRet) nextPc <= retPc;

      if (strobe.trapM) begin
        statMpie <= statMie; statMie <= 1'b0; statMpp <= curPriv;
        mepc <= faultPc; mtval <= tvalWord; mcause <= causeWord;
        curPriv <= PRIV_M;
      end
      if (strobe.trapS) begin
        statSpie <= statSie; statSie <= 1'b0; statSpp <= (curPriv != PRIV_U);
        sepc <= faultPc; stval <= tvalWord; scause <= causeWord;
        curPriv <= PRIV_S;
      end
      if (strobe.trapU) begin
        statUpie <= statUie; statUie <= 1'b0;
        uepc <= faultPc; utval <= tvalWord; ucause <= causeWord;
        curPriv <= PRIV_U;
      end
      if (strobe.doMret) begin
        statMie <= statMpie; statMpie <= 1'b1;
        curPriv <= (statMpp == 2'b10) ? PRIV_M : statMpp;
        statMpp <= RET_MPP;
      end
      if (strobe.doSret) begin
        statSie <= statSpie; statSpie <= 1'b1;
        curPriv <= statSpp ? PRIV_S : PRIV_U;
        statSpp <= 1'b0;
      end
      if (strobe.doUret) begin
        statUie <= statUpie; statUpie <= 1'b1;
        curPriv <= PRIV_U;
      end
    end
  end
endmodule

// File: rtl/trap_return_seq.sv
module trap_return_seq
  import trap_return_seq_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CODE_W    = 5,
  parameter bit HAVE_SUP  = 1'b1,
  parameter bit HAVE_USR  = 1'b1,
  parameter bit HAVE_UEXT = 1'b1,
  parameter bit HAVE_RVC  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              excValid,
  input  logic              intValid,
  input  logic              mretReq,
  input  logic              sretReq,
  input  logic              uretReq,
  input  logic [CODE_W-1:0] causeCode,
  input  logic [1:0]        intLevel,
  input  logic [XLEN-1:0]   faultPc,
  input  logic              infoValid,
  input  logic [XLEN-1:0]   infoVal,
  input  logic [XLEN-1:0]   medeleg,
  input  logic [XLEN-1:0]   sedeleg,
  input  logic [XLEN-1:0]   mtvec,
  input  logic [XLEN-1:0]   stvec,
  input  logic [XLEN-1:0]   utvec,
  output logic [1:0]        curPriv,
  output logic              statMie,
  output logic              statMpie,
  output logic [1:0]        statMpp,
  output logic              statSie,
  output logic              statSpie,
  output logic              statSpp,
  output logic              statUie,
  output logic              statUpie,
  output logic [XLEN-1:0]   mcause,
  output logic [XLEN-1:0]   mepc,
  output logic [XLEN-1:0]   mtval,
  output logic [XLEN-1:0]   scause,
  output logic [XLEN-1:0]   sepc,
  output logic [XLEN-1:0]   stval,
  output logic [XLEN-1:0]   ucause,
  output logic [XLEN-1:0]   uepc,
  output logic [XLEN-1:0]   utval,
  output logic [XLEN-1:0]   nextPc,
  output logic              nextPcValid,
  output logic              resvCancel,
  output logic              tvecErr
);
  seqStrobe_t strobe;

  trap_return_seq_ctrl #(
    .XLEN(XLEN), .CODE_W(CODE_W), .HAVE_SUP(HAVE_SUP),
    .HAVE_USR(HAVE_USR), .HAVE_UEXT(HAVE_UEXT)
  ) uCtrl (
    .excValid(excValid), .intValid(intValid), .mretReq(mretReq),
    .sretReq(sretReq), .uretReq(uretReq), .causeCode(causeCode),
    .intLevel(intLevel), .curPriv(curPriv), .medeleg(medeleg),
    .sedeleg(sedeleg), .strobe(strobe)
  );

  trap_return_seq_dpath #(
    .XLEN(XLEN), .CODE_W(CODE_W), .HAVE_USR(HAVE_USR), .HAVE_RVC(HAVE_RVC)
  ) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .causeCode(causeCode),
    .faultPc(faultPc), .infoValid(infoValid), .infoVal(infoVal),
    .mtvec(mtvec), .stvec(stvec), .utvec(utvec),
    .curPriv(curPriv), .statMie(statMie), .statMpie(statMpie), .statMpp(statMpp),
    .statSie(statSie), .statSpie(statSpie), .statSpp(statSpp),
    .statUie(statUie), .statUpie(statUpie),
    .mcause(mcause), .mepc(mepc), .mtval(mtval),
    .scause(scause), .sepc(sepc), .stval(stval),
    .ucause(ucause), .uepc(uepc), .utval(utval),
    .nextPc(nextPc), .nextPcValid(nextPcValid), .resvCancel(resvCancel),
    .tvecErr(tvecErr)
  );
endmodule

// File: rtl/trap_return_seq_chk.sv
module trap_return_seq_chk #(
  parameter bit HAVE_USR = 1'b1
) (
  input logic       clk,
  input logic       rstN,
  input logic       excValid,
  input logic       intValid,
  input logic       mretReq,
  input logic       sretReq,
  input logic       uretReq,
  input logic [1:0] curPriv,
  input logic       statMie,
  input logic       statMpie,
  input logic [1:0] statMpp,
  input logic       statSpie,
  input logic       statSpp,
  input logic       statUpie,
  input logic       nextPcValid,
  input logic       resvCancel,
  input logic       tvecErr
);
  localparam logic [1:0] EXP_MPP = HAVE_USR ? 2'b00 : 2'b11;
  logic anyReq, noTrap;
  assign anyReq = excValid | intValid | mretReq | sretReq | uretReq;
  assign noTrap = !excValid && !intValid;

  AST_REQ_PULSES: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |=> (nextPcValid && resvCancel)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |=> (!nextPcValid && !resvCancel && $stable(curPriv))); // R12
  AST_NO_LOWER: assert property (@(posedge clk) disable iff (!rstN)
    excValid |=> (curPriv >= $past(curPriv))); // R3
  AST_MTRAP_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    (intValid || excValid) |=> (curPriv != 2'b11 || !statMie)); // R4
  AST_MRET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (noTrap && mretReq) |=> (statMpie && statMpp == EXP_MPP && statMie == $past(statMpie))); // R8
  AST_SRET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (noTrap && !mretReq && sretReq) |=> (statSpie && !statSpp)); // R9
  AST_URET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (noTrap && !mretReq && !sretReq && uretReq) |=> (statUpie && curPriv == 2'b00)); // R10
  AST_VECERR_WITH_PC: assert property (@(posedge clk) disable iff (!rstN)
    tvecErr |-> nextPcValid); // R7
endmodule

bind trap_return_seq trap_return_seq_chk #(.HAVE_USR(HAVE_USR)) uChk (
  .clk(clk), .rstN(rstN), .excValid(excValid), .intValid(intValid),
  .mretReq(mretReq), .sretReq(sretReq), .uretReq(uretReq), .curPriv(curPriv),
  .statMie(statMie), .statMpie(statMpie), .statMpp(statMpp),
  .statSpie(statSpie), .statSpp(statSpp), .statUpie(statUpie),
  .nextPcValid(nextPcValid), .resvCancel(resvCancel), .tvecErr(tvecErr)
);

// File: tb/sim_trap_return_seq.sv
`timescale 1ns/1ps
module sim_trap_return_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excValid = 0, intValid = 0, mretReq = 0, sretReq = 0, uretReq = 0;
  logic [4:0]  causeCode = '0;
  logic [1:0]  intLevel = '0;
  logic [31:0] faultPc = '0, infoVal = '0;
  logic        infoValid = 0;
  logic [31:0] medeleg = '0, sedeleg = '0, mtvec = '0, stvec = '0, utvec = '0;
  logic [1:0]  curPriv, statMpp;
  logic        statMie, statMpie, statSie, statSpie, statSpp, statUie, statUpie;
  logic [31:0] mcause, mepc, mtval, scause, sepc, stval, ucause, uepc, utval, nextPc;
  logic        nextPcValid, resvCancel, tvecErr;

  int vecCnt = 0;
  int errCnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trap_return_seq u0 (
    .clk(clk), .rstN(rstN), .excValid(excValid), .intValid(intValid),
    .mretReq(mretReq), .sretReq(sretReq), .uretReq(uretReq),
    .causeCode(causeCode), .intLevel(intLevel), .faultPc(faultPc),
    .infoValid(infoValid), .infoVal(infoVal), .medeleg(medeleg), .sedeleg(sedeleg),
    .mtvec(mtvec), .stvec(stvec), .utvec(utvec),
    .curPriv(curPriv), .statMie(statMie), .statMpie(statMpie), .statMpp(statMpp),
    .statSie(statSie), .statSpie(statSpie), .statSpp(statSpp),
    .statUie(statUie), .statUpie(statUpie),
    .mcause(mcause), .mepc(mepc), .mtval(mtval),
    .scause(scause), .sepc(sepc), .stval(stval),
    .ucause(ucause), .uepc(uepc), .utval(utval),
    .nextPc(nextPc), .nextPcValid(nextPcValid), .resvCancel(resvCancel),
    .tvecErr(tvecErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request for one cycle; return at the negedge after the applying edge
  task automatic issue(input logic e, input logic i, input logic m, input logic s,
                       input logic u, input logic [4:0] code, input logic [1:0] lvl,
                       input logic [31:0] pc, input logic iv, input logic [31:0] info);
    @(negedge clk);
    excValid = e; intValid = i; mretReq = m; sretReq = s; uretReq = u;
    causeCode = code; intLevel = lvl; faultPc = pc; infoValid = iv; infoVal = info;
    @(negedge clk);
    excValid = 0; intValid = 0; mretReq = 0; sretReq = 0; uretReq = 0;
  endtask

  task automatic pulsesOn(input string tag);
    chk({tag, " nextPcValid"}, 32'(nextPcValid), 32'd1);
    chk({tag, " resvCancel"}, 32'(resvCancel), 32'd1);
  endtask

  task automatic testReset();
    chk("R1 priv", 32'(curPriv), 32'd3);
    chk("R1 status", {24'd0, statMie, statMpie, statMpp, statSie, statSpie, statSpp, statUie}, 32'd0);
    chk("R1 upie", 32'(statUpie), 32'd0);
    chk("R1 mcause", mcause, 0); chk("R1 mepc", mepc, 0); chk("R1 mtval", mtval, 0);
    chk("R1 sepc", sepc, 0); chk("R1 uepc", uepc, 0); chk("R1 scause", scause, 0);
    chk("R1 strobes", {29'd0, nextPcValid, resvCancel, tvecErr}, 32'd0);
  endtask

  task automatic testMachineTrap();
    medeleg = '0; sedeleg = '0; mtvec = 32'h1000; stvec = 32'h3001; utvec = 32'h4000;
    issue(1, 0, 0, 0, 0, 5'd2, 2'd0, 32'h2003, 1, 32'hDEAD);
    chk("R2 M target", 32'(curPriv), 32'd3);
    chk("R4 mepc", mepc, 32'h2003); chk("R4 mtval", mtval, 32'hDEAD);
    chk("R4 mcause", mcause, 32'd2); chk("R4 mpp", 32'(statMpp), 32'd3);
    chk("R4 mie/mpie", {30'd0, statMie, statMpie}, 32'd0);
    chk("R7 direct", nextPc, 32'h1000); chk("R7 no err", 32'(tvecErr), 32'd0);
    pulsesOn("R12 trap");
  endtask

  task automatic testMret();
    issue(0, 0, 1, 0, 0, 5'd0, 2'd0, 32'h0, 0, 32'h0);
    chk("R8 priv", 32'(curPriv), 32'd3);
    chk("R8 mie", 32'(statMie), 32'd0); chk("R8 mpie", 32'(statMpie), 32'd1);
    chk("R8 mpp", 32'(statMpp), 32'd0);
    chk("R11 ret pc", nextPc, 32'h2002);
    pulsesOn("R12 mret");
    issue(0, 0, 1, 0, 0, 5'd0, 2'd0, 32'h0, 0, 32'h0);
    chk("R8 priv user", 32'(curPriv), 32'd0);
    chk("R8 mie set", 32'(statMie), 32'd1);
  endtask

  task automatic testSupTrapAndReturn();
    medeleg = 32'h0000_0128; sedeleg = 32'h0000_0108;
    issue(1, 0, 0, 0, 0, 5'd5, 2'd0, 32'h5000, 0, 32'h77);
    chk("R2 S target", 32'(curPriv), 32'd1);
    chk("R5 spp from U", 32'(statSpp), 32'd0);
    chk("R5 sie/spie", {30'd0, statSie, statSpie}, 32'd0);
    chk("R5 sepc", sepc, 32'h5000); chk("R5 stval zero", stval, 32'd0);
    chk("R5 scause", scause, 32'd5);
    chk("R7 vectored exc", nextPc, 32'h3000);
    chk("R4 mepc kept", mepc, 32'h2003);
    issue(0, 0, 0, 1, 0, 5'd0, 2'd0, 32'h0, 0, 32'h0);
    chk("R9 priv", 32'(curPriv), 32'd0);
    chk("R9 spie", 32'(statSpie), 32'd1); chk("R9 sie", 32'(statSie), 32'd0);
    chk("R11 sret pc", nextPc, 32'h5000);
  endtask

  task automatic testUserTrapAndReturn();
    issue(1, 0, 0, 0, 0, 5'd8, 2'd0, 32'h6001, 1, 32'h88);
    chk("R2 U target", 32'(curPriv), 32'd0);
    chk("R6 uepc", uepc, 32'h6001); chk("R6 utval", utval, 32'h88);
    chk("R6 ucause", ucause, 32'd8);
    chk("R6 uie/upie", {30'd0, statUie, statUpie}, 32'd0);
    chk("R7 utvec", nextPc, 32'h4000);
    issue(0, 0, 0, 0, 1, 5'd0, 2'd0, 32'h0, 0, 32'h0);
    chk("R10 priv", 32'(curPriv), 32'd0);
    chk("R10 upie", 32'(statUpie), 32'd1); chk("R10 uie", 32'(statUie), 32'd0);
    chk("R11 uret pc", nextPc, 32'h6000);
    pulsesOn("R12 uret");
  endtask

  task automatic testInterruptAndClamp();
    issue(0, 1, 0, 0, 0, 5'd9, 2'd1, 32'h7000, 0, 32'h0);
    chk("R5 int priv", 32'(curPriv), 32'd1);
    chk("R5 int scause", scause, 32'h8000_0009);
    chk("R7 vectored int", nextPc, 32'h3024);
    issue(1, 0, 0, 0, 0, 5'd3, 2'd0, 32'h7100, 1, 32'h31);
    chk("R3 clamp priv", 32'(curPriv), 32'd1);
    chk("R5 spp from S", 32'(statSpp), 32'd1);
    chk("R5 scause exc", scause, 32'd3); chk("R5 stval", stval, 32'h31);
    chk("R3 uepc kept", uepc, 32'h6001);
    issue(0, 0, 0, 1, 0, 5'd0, 2'd0, 32'h0, 0, 32'h0);
    chk("R9 back to S", 32'(curPriv), 32'd1);
    chk("R9 spp cleared", 32'(statSpp), 32'd0);
    chk("R11 sret pc", nextPc, 32'h7100);
  endtask

  task automatic testBadModeAndPriority();
    mtvec = 32'h1002;
    issue(0, 1, 0, 0, 0, 5'd11, 2'd3, 32'h8000, 0, 32'h0);
    chk("R7 bad mode err", 32'(tvecErr), 32'd1);
    chk("R7 bad mode pc", nextPc, 32'h1000);
    chk("R4 mpp from S", 32'(statMpp), 32'd1);
    chk("R4 mpie from mie", 32'(statMpie), 32'd1);
    chk("R4 int mcause", mcause, 32'h8000_000B);
    mtvec = 32'h1000;
    issue(1, 0, 1, 0, 0, 5'd2, 2'd0, 32'h9000, 0, 32'h0);
    chk("R13 exc over mret priv", 32'(curPriv), 32'd3);
    chk("R13 exc over mret mcause", mcause, 32'd2);
    chk("R13 exc over mret mepc", mepc, 32'h9000);
    chk("R13 mpp", 32'(statMpp), 32'd3);
    issue(0, 1, 0, 1, 0, 5'd7, 2'd0, 32'hA000, 0, 32'h0);
    chk("R13 int over sret mcause", mcause, 32'h8000_0007);
    chk("R3 int clamp priv", 32'(curPriv), 32'd3);
    chk("R13 sret ignored spie", 32'(statSpie), 32'd1);
  endtask

  task automatic testIdle();
    @(negedge clk);
    chk("R12 idle valid", 32'(nextPcValid), 32'd0);
    chk("R12 idle cancel", 32'(resvCancel), 32'd0);
    chk("R12 idle priv", 32'(curPriv), 32'd3);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  endtask

  initial begin
    #160000;
    errCnt++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMachineTrap();
    testMret();
    testSupTrapAndReturn();
    testUserTrapAndReturn();
    testInterruptAndClamp();
    testBadModeAndPriority();
    testIdle();
    finishRun();
  end
endmodule